// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Table

This block applies gamma correction to pixels for several independent output channels. Each channel has three 256-entry tables of 8-bit values, one for each of red, green and blue. A pixel enters with a channel number, a gamma-enable flag and three 8-bit components. Two cycles later it leaves with each component replaced by its table entry. If the flag is clear, or the channel number names no channel, the components leave unchanged after the same two cycles.

Software loads the tables through a register-style pair of write ports. An address write sets a flat table address and latches an auto-increment flag. Each data write then stores one 8-bit entry at that address and, if the flag is set, moves the address on by one. The flat map is channel-major and then colour-major. Channel c, colour k (red 0, green 1, blue 2), level v sits at address c*768 + k*256 + v. A whole channel therefore loads with a single address write of c*768 followed by 768 data writes.

Top module: `gamma_lut_top`

## Requirements
- R1: While reset is asserted and after it is released, `pixValidOut` is 0 until a valid pixel has passed through the pipeline.
- R2: The entry for channel c, colour k (red 0, green 1, blue 2) and level v is at flat address c*768 + k*256 + v, and each colour's output comes from its own colour's entries.
- R3: An address write with `addrAutoInc` set makes every following data write advance the address by one.
- R4: After an address write with `addrAutoInc` clear, repeated data writes overwrite the same entry and leave its neighbours unchanged.
- R5: With auto-increment on, a data write to address 2303 (the last entry) moves the address to 0.
- R6: A data write in the same cycle as an address write stores its data at the newly written address and follows the newly written auto-increment flag.
- R7: An address write of a value at or above 2304 sets the address to 0.
- R8: A pixel whose gamma-enable is 0, or whose channel number is 3 or more, leaves with its R, G and B unchanged.
- R9: A pixel presented with `pixValidIn` before clock edge k appears with `pixValidOut` after edge k+1, whether it is corrected or bypassed. Back-to-back pixels are accepted every cycle.
- R10: A pixel presented before edge k reads its entries as they stood before any data write taken at edge k+1. A write at edge k+1 to an entry that pixel uses does not change its output.
- R11: A pixel with gamma-enable 1 and a valid channel leaves with R, G and B each replaced by that channel's entry for the component's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrWe | input | 1 | Address register write strobe |
| addrIn | input | 12 | Flat table address to load |
| addrAutoInc | input | 1 | Auto-increment flag latched with the address |
| dataWe | input | 1 | Data register write strobe |
| dataIn | input | 8 | Table entry value to store |
| pixValidIn | input | 1 | Input pixel qualifier |
| pixChan | input | 2 | Channel number of the input pixel |
| pixGammaEn | input | 1 | 1 applies the table, 0 passes the pixel through |
| pixRIn | input | 8 | Red component in |
| pixGIn | input | 8 | Green component in |
| pixBIn | input | 8 | Blue component in |
| pixValidOut | output | 1 | Output pixel qualifier |
| pixROut | output | 8 | Red component out |
| pixGOut | output | 8 | Green component out |
| pixBOut | output | 8 | Blue component out |

## Verification
The bench builds the block with its default parameters: three channels and 8-bit components. That gives a 2304-entry flat map, so one unbroken load can run past the last entry and show the wrap to 0. The 2-bit channel field leaves code 3 spare for the out-of-range bypass, and the 12-bit address field reaches values such as 3000 that lie beyond the map. A behavioural model tracks the flat address and a plain array of entries, and every cycle it is compared with the pixel outputs. These cases are covered:
- write-during-read collisions
- address and data writes in the same cycle
- non-incrementing overwrites
- mixed bypass and corrected traffic

// File: rtl/gamma_pkg.sv
package gamma_pkg;

  localparam int NUM_COLOURS = 3;

  typedef struct packed {
    logic                   wrEn;
    logic [NUM_COLOURS-1:0] bankSel;
  } lutStrobe_t;

endpackage

// File: rtl/gamma_bank.sv
module gamma_bank #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = NUM_CH << DATA_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Nonblocking write and read at the same edge: a colliding read sees the old entry.
  always_ff @(posedge clk) begin
    if (wrEn) begin
      mem[wrIdx] <= wrData;
    end
    rdData <= mem[rdIdx];
  end

endmodule

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl
  import gamma_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrAutoInc,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  output lutStrobe_t        strobe,
  output logic [CH_W-1:0]   wrCh,
  output logic [DATA_W-1:0] wrLvl,
  output logic [DATA_W-1:0] wrData
);

  localparam int LEVELS  = 1 << DATA_W;
  localparam int CH_SPAN = NUM_COLOURS * LEVELS;
  localparam int TOTAL   = NUM_CH * CH_SPAN;
  localparam logic [DATA_W-1:0] LVL_MAX = DATA_W'(LEVELS - 1);
  localparam logic [1:0]        COL_MAX = 2'(NUM_COLOURS - 1);
  localparam logic [CH_W-1:0]   CH_MAX  = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0]   chQ, decCh, effCh, nxtCh;
  logic [1:0]        colQ, decCol, effCol, nxtCol;
  logic [DATA_W-1:0] lvlQ, decLvl, effLvl, nxtLvl;
  logic              incQ, effInc;

  // Split a flat address into channel, colour and level fields.
  always_comb begin
    int flat;
    int rem;
    flat  = (int'(addrIn) >= TOTAL) ? 0 : int'(addrIn);
    decCh = '0;
    for (int c = 1; c < NUM_CH; c++) begin
      if (flat >= c * CH_SPAN) begin
        decCh = CH_W'(c);
      end
    end
    rem = flat - int'(decCh) * CH_SPAN;
    if (rem >= 2 * LEVELS) begin
      decCol = 2'd2;
    end else if (rem >= LEVELS) begin
      decCol = 2'd1;
    end else begin
      decCol = 2'd0;
    end
    decLvl = DATA_W'(rem);
  end

  // A simultaneous address write takes effect for this cycle's data write.
  always_comb begin
    if (addrWe) begin
      effCh  = decCh;
      effCol = decCol;
      effLvl = decLvl;
      effInc = addrAutoInc;
    end else begin
      effCh  = chQ;
      effCol = colQ;
      effLvl = lvlQ;
      effInc = incQ;
    end
  end

  // Cascaded field increment with wrap of the whole map to address 0.
  always_comb begin
    nxtCh  = effCh;
    nxtCol = effCol;
    nxtLvl = effLvl;
    if (dataWe && effInc) begin
      if (effLvl == LVL_MAX) begin
        nxtLvl = '0;
        if (effCol == COL_MAX) begin
          nxtCol = '0;
          nxtCh  = (effCh == CH_MAX) ? '0 : effCh + 1'b1;
        end else begin
          nxtCol = effCol + 1'b1;
        end
      end else begin
        nxtLvl = effLvl + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chQ  <= '0;
      colQ <= '0;
      lvlQ <= '0;
      incQ <= 1'b0;
    end else begin
      chQ  <= nxtCh;
      colQ <= nxtCol;
      lvlQ <= nxtLvl;
      incQ <= effInc;
    end
  end

  always_comb begin
    strobe.wrEn    = dataWe;
    strobe.bankSel = '0;
    for (int k = 0; k < NUM_COLOURS; k++) begin
      strobe.bankSel[k] = dataWe && (effCol == 2'(k));
    end
  end

  assign wrCh   = effCh;
  assign wrLvl  = effLvl;
  assign wrData = dataIn;

  a_r2_one_bank: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> $countones(strobe.bankSel) == 1);

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && !addrWe && incQ && lvlQ != LVL_MAX) |=>
      (lvlQ == $past(lvlQ) + 1'b1) && $stable(colQ) && $stable(chQ));

  a_r4_no_step: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && !addrWe && !incQ) |=> $stable(lvlQ) && $stable(colQ) && $stable(chQ));

  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && !addrWe && incQ && chQ == CH_MAX && colQ == COL_MAX && lvlQ == LVL_MAX) |=>
      (chQ == '0 && colQ == '0 && lvlQ == '0));

  a_r7_range_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addrWe && !dataWe && int'(addrIn) >= TOTAL) |=> (chQ == '0 && colQ == '0 && lvlQ == '0));

  a_r2_field_range: assert property (@(posedge clk) disable iff (!rstN)
    (int'(chQ) < NUM_CH) && (colQ <= COL_MAX));

endmodule

// File: rtl/gamma_datapath.sv
module gamma_datapath
  import gamma_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lutStrobe_t        strobe,
  input  logic [CH_W-1:0]   wrCh,
  input  logic [DATA_W-1:0] wrLvl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pixValidIn,
  input  logic [CH_W-1:0]   pixChan,
  input  logic              pixGammaEn,
  input  logic [DATA_W-1:0] pixRIn,
  input  logic [DATA_W-1:0] pixGIn,
  input  logic [DATA_W-1:0] pixBIn,
  output logic              pixValidOut,
  output logic [DATA_W-1:0] pixROut,
  output logic [DATA_W-1:0] pixGOut,
  output logic [DATA_W-1:0] pixBOut
);

  localparam int IDX_W = CH_W + DATA_W;

  logic                          s1Valid, s1Use;
  logic [CH_W-1:0]               s1Ch;
  logic [NUM_COLOURS-1:0][DATA_W-1:0] s1Pix, s2Raw, bankOut;
  logic                          s2Valid, s2Use;

  // Stage 1: capture the pixel; out-of-range channels fall back to bypass.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Use   <= 1'b0;
      s1Ch    <= '0;
      s1Pix   <= '0;
    end else begin
      s1Valid <= pixValidIn;
      s1Use   <= pixGammaEn && (int'(pixChan) < NUM_CH);
      s1Ch    <= pixChan;
      s1Pix   <= {pixBIn, pixGIn, pixRIn};
    end
  end

  // Stage 2: raw copy travels beside the table read so both paths see equal latency.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Use   <= 1'b0;
      s2Raw   <= '0;
    end else begin
      s2Valid <= s1Valid;
      s2Use   <= s1Use;
      s2Raw   <= s1Pix;
    end
  end

  for (genvar k = 0; k < NUM_COLOURS; k++) begin : g_bank
    logic [IDX_W-1:0] rdIdx;
    assign rdIdx = s1Use ? {s1Ch, s1Pix[k]} : '0;
    gamma_bank #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) bank_i (
      .clk    (clk),
      .wrEn   (strobe.bankSel[k]),
      .wrIdx  ({wrCh, wrLvl}),
      .wrData (wrData),
      .rdIdx  (rdIdx),
      .rdData (bankOut[k])
    );
  end

  assign pixValidOut = s2Valid;
  assign pixROut     = s2Use ? bankOut[0] : s2Raw[0];
  assign pixGOut     = s2Use ? bankOut[1] : s2Raw[1];
  assign pixBOut     = s2Use ? bankOut[2] : s2Raw[2];

  a_r8_bypass_equal: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !s1Use) |=> {pixBOut, pixGOut, pixROut} == $past(s1Pix));

  a_r8_bad_chan_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (pixValidIn && int'(pixChan) >= NUM_CH) |=> !s1Use);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    pixValidIn |=> s1Valid);

  a_r9_valid_out: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> pixValidOut);

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = $clog2(NUM_CH * NUM_COLOURS * (1 << DATA_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrAutoInc,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              pixValidIn,
  input  logic [CH_W-1:0]   pixChan,
  input  logic              pixGammaEn,
  input  logic [DATA_W-1:0] pixRIn,
  input  logic [DATA_W-1:0] pixGIn,
  input  logic [DATA_W-1:0] pixBIn,
  output logic              pixValidOut,
  output logic [DATA_W-1:0] pixROut,
  output logic [DATA_W-1:0] pixGOut,
  output logic [DATA_W-1:0] pixBOut
);

  lutStrobe_t        strobe;
  logic [CH_W-1:0]   wrCh;
  logic [DATA_W-1:0] wrLvl;
  logic [DATA_W-1:0] wrData;

  gamma_addr_ctrl #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .addrWe      (addrWe),
    .addrIn      (addrIn),
    .addrAutoInc (addrAutoInc),
    .dataWe      (dataWe),
    .dataIn      (dataIn),
    .strobe      (strobe),
    .wrCh        (wrCh),
    .wrLvl       (wrLvl),
    .wrData      (wrData)
  );

  gamma_datapath #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrCh        (wrCh),
    .wrLvl       (wrLvl),
    .wrData      (wrData),
    .pixValidIn  (pixValidIn),
    .pixChan     (pixChan),
    .pixGammaEn  (pixGammaEn),
    .pixRIn      (pixRIn),
    .pixGIn      (pixGIn),
    .pixBIn      (pixBIn),
    .pixValidOut (pixValidOut),
    .pixROut     (pixROut),
    .pixGOut     (pixGOut),
    .pixBOut     (pixBOut)
  );

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstN) |-> !pixValidOut));

endmodule

// File: tb/gamma_lut_top_tb_top.sv
module gamma_lut_top_tb_top;

  localparam int TOTAL = 2304;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrWe = 1'b0;
  logic [11:0] addrIn = '0;
  logic addrAutoInc = 1'b0;
  logic dataWe = 1'b0;
  logic [7:0] dataIn = '0;
  logic pixValidIn = 1'b0;
  logic [1:0] pixChan = '0;
  logic pixGammaEn = 1'b0;
  logic [7:0] pixRIn = '0, pixGIn = '0, pixBIn = '0;
  logic pixValidOut;
  logic [7:0] pixROut, pixGOut, pixBOut;

  always #5 clk = ~clk;

  gamma_lut_top dut_i (
    .clk(clk), .rstN(rstN), .addrWe(addrWe), .addrIn(addrIn),
    .addrAutoInc(addrAutoInc), .dataWe(dataWe), .dataIn(dataIn),
    .pixValidIn(pixValidIn), .pixChan(pixChan), .pixGammaEn(pixGammaEn),
    .pixRIn(pixRIn), .pixGIn(pixGIn), .pixBIn(pixBIn),
    .pixValidOut(pixValidOut), .pixROut(pixROut), .pixGOut(pixGOut), .pixBOut(pixBOut)
  );

  int checks = 0;
  int failures = 0;
  string curTag = "R9";

  // Behavioural reference: flat entry array, flat address, one staged pixel.
  int mem [TOTAL];
  int mAddr = 0;
  bit mInc = 0;
  bit m1Valid = 0, m1Use = 0;
  int m1Ch = 0, m1R = 0, m1G = 0, m1B = 0;
  string m1Tag = "";
  bit expValid = 0;
  int expR = 0, expG = 0, expB = 0;
  string expTag = "";

  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0; m1Valid = 0; mAddr = 0; mInc = 0;
    end else begin
      expValid = m1Valid;
      expTag = m1Tag;
      if (m1Use) begin
        expR = mem[m1Ch * 768 + 0 * 256 + m1R];
        expG = mem[m1Ch * 768 + 1 * 256 + m1G];
        expB = mem[m1Ch * 768 + 2 * 256 + m1B];
      end else begin
        expR = m1R; expG = m1G; expB = m1B;
      end
      m1Valid = pixValidIn;
      m1Use = pixGammaEn && (int'(pixChan) < 3);
      m1Ch = int'(pixChan);
      m1R = int'(pixRIn); m1G = int'(pixGIn); m1B = int'(pixBIn);
      m1Tag = curTag;
      if (addrWe) begin
        mAddr = (int'(addrIn) >= TOTAL) ? 0 : int'(addrIn);
        mInc = addrAutoInc;
      end
      if (dataWe) begin
        mem[mAddr] = int'(dataIn);
        if (mInc) mAddr = (mAddr + 1) % TOTAL;
      end
    end
  end

  bit cmpOn = 0;
  always @(negedge clk) begin
    if (cmpOn) begin
      checks++;
      if (pixValidOut !== expValid) begin
        failures++;
        $display("FAIL %s valid: actual=%0b expected=%0b", expTag, pixValidOut, expValid);
      end else if (expValid) begin
        checks++;
        if (int'(pixROut) != expR || int'(pixGOut) != expG || int'(pixBOut) != expB) begin
          failures++;
          $display("FAIL %s pixel: actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                   expTag, pixROut, pixGOut, pixBOut, expR, expG, expB);
        end
      end
    end
  end

  int cycleCount = 0;
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycleCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input bit aWe, input int aVal, input bit aInc,
                     input bit dWe, input int dVal,
                     input bit pV, input int pCh, input bit pEn,
                     input int r, input int g, input int b);
    addrWe = aWe; addrIn = 12'(aVal); addrAutoInc = aInc;
    dataWe = dWe; dataIn = 8'(dVal);
    pixValidIn = pV; pixChan = 2'(pCh); pixGammaEn = pEn;
    pixRIn = 8'(r); pixGIn = 8'(g); pixBIn = 8'(b);
    @(negedge clk);
  endtask

  task automatic pix(input int ch, input bit en, input int r, input int g, input int b);
    cyc(0, 0, 0, 0, 0, 1, ch, en, r, g, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: output idle during reset
    checks++;
    if (pixValidOut !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset valid: actual=%0b expected=0", pixValidOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (pixValidOut !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset valid: actual=%0b expected=0", pixValidOut);
    end
    cmpOn = 1;

    curTag = "R8";
    for (int i = 0; i < 8; i++) pix(i % 4, 0, $urandom % 256, $urandom % 256, $urandom % 256);

    curTag = "R3";
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < TOTAL; i++) cyc(0, 0, 0, 1, (i * 37 + 11) % 256, 0, 0, 0, 0, 0, 0);

    curTag = "R5";
    cyc(0, 0, 0, 1, 165, 0, 0, 0, 0, 0, 0);
    pix(0, 1, 0, 1, 2);

    curTag = "R11";
    for (int i = 0; i < 64; i++) pix(i % 3, 1, $urandom % 256, $urandom % 256, $urandom % 256);

    curTag = "R2";
    pix(2, 1, 255, 0, 128);
    pix(1, 1, 0, 255, 7);

    curTag = "R8";
    for (int i = 0; i < 12; i++)
      pix((i % 2 == 0) ? 3 : i % 3, (i % 2 == 0), $urandom % 256, $urandom % 256, $urandom % 256);

    curTag = "R4";
    cyc(1, 768 + 256 + 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 17, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 34, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 51, 0, 0, 0, 0, 0, 0);
    pix(1, 1, 0, 5, 0);
    pix(1, 1, 0, 6, 0);
    pix(1, 1, 0, 4, 0);

    curTag = "R6";
    cyc(1, 1536 + 512 + 7, 1, 1, 60, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 61, 0, 0, 0, 0, 0, 0);
    pix(2, 1, 0, 0, 7);
    pix(2, 1, 0, 0, 8);

    curTag = "R7";
    cyc(1, 3000, 0, 1, 119, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 120, 0, 0, 0, 0, 0, 0);
    pix(0, 1, 0, 0, 0);

    curTag = "R10";
    cyc(1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    pix(0, 1, 9, 9, 9);
    cyc(0, 0, 0, 1, 238, 1, 0, 1, 9, 9, 9);
    pix(0, 1, 9, 9, 9);

    curTag = "R9";
    for (int i = 0; i < 16; i++) begin
      if (i % 5 == 4) idle(1);
      else pix(i % 3, i[0], $urandom % 256, $urandom % 256, $urandom % 256);
    end
    idle(4);

    cmpOn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule